// File: doc/BRIEF.md
# ADC Sample Sequencer FIFO

This block is one sampling sequencer of an analogue-to-digital front-end. Each pulse on the trigger input, when the sequencer is enabled, produces one conversion result and pushes it into a 16-entry result FIFO. No real converter is attached. Results come from a 32-bit linear-congruential noise generator, so that software reading the ADC as an entropy source still sees variation.

Software reaches the block through a simple register port with single-cycle read and write strobes. Reading the pop register takes the oldest result out of the FIFO. A packed status word shows both pointers and the empty and full flags. Each accepted trigger sets a raw interrupt bit. The interrupt output is the raw bits ANDed with a mask, and software clears raw bits by writing ones. Pushing into a full FIFO and popping from an empty FIFO each leave a sticky error flag.

Top module: `adc_seq_fifo`

## Requirements
- R1: After reset the status word (window offset 0x4C) reads 0x100, meaning empty with both pointers at zero. The enable, raw, mask and error registers read 0, and `irq` is low.
- R2: A trigger changes nothing while bit 0 of the enable register (offset 0x00) is clear: the status word, the raw interrupt bits and the FIFO contents stay as they were.
- R3: The enable register keeps only bits 3:0 of a write and reads the other bits as zero.
- R4: An accepted trigger writes at the head, advances the head modulo 16 and clears empty (bit 8). When the new head equals the tail it sets full (bit 12). The status word holds the tail in bits 3:0 and the head in bits 7:4.
- R5: A trigger that arrives while the FIFO is full stores nothing and moves no pointer. It sets the overflow flag, bit 0 of the error register at offset 0x10.
- R6: A read of the pop register (window offset 0x48) returns the oldest entry, advances the tail modulo 16 and clears full. When the new tail equals the head it sets empty. Results come out in the order they were pushed.
- R7: A pop from an empty FIFO returns 0 and moves no pointer. It sets the underflow flag, bit 1 of the error register.
- R8: The noise state is 32 bits and resets to 0. Every accepted trigger replaces it with state*314159+1, wrapping at 32 bits, even when the push is then discarded. The pushed value is 0x200 plus bits 18:16 of the new state.
- R9: Every accepted trigger sets raw bit 0, readable at offset 0x04. `irq` equals the OR of raw AND mask, where the mask is at offset 0x08 and keeps 4 bits. Offset 0x0C reads raw AND mask.
- R10: Writing a 1 to a bit at offset 0x0C clears that raw bit. A trigger in the same cycle wins.
- R11: Writing a 1 to a bit of the error register clears that flag.
- R12: The input-select register (window offset 0x40) stores the written value ANDed with 0x33333333. The control register (window offset 0x44) stores all 32 bits.
- R13: The sequencer window decodes offsets 0x40 to 0x5F. Reads in the unused sequencer windows 0x60 to 0xBF return 0, and reads or writes there have no side effect on this FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of the pop register removes an entry |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from current state |
| trig | input | 1 | Conversion trigger, one push per cycle high |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest states to reach are the pointer wrap and the full/empty boundaries at pointer values other than zero. Reaching them needs long, ordered runs of triggers and pops. The bench fills the FIFO past full, drains it past empty, and then runs a long pattern of two pushes to one pop followed by a drain. That pattern moves head and tail through every value more than once, and each status word is checked against a pointer model kept in the bench. Overflow and underflow are provoked on purpose and checked through the sticky error register, and the sampled values are compared with an independently computed noise sequence.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int REG_W = 32;

  // global register offsets
  localparam logic [7:0] OFF_ENABLE = 8'h00;
  localparam logic [7:0] OFF_RAW    = 8'h04;
  localparam logic [7:0] OFF_MASK   = 8'h08;
  localparam logic [7:0] OFF_MIS    = 8'h0C;
  localparam logic [7:0] OFF_ERR    = 8'h10;

  // sequencer 0 window base bits [7:5] and sub-offsets
  localparam logic [2:0] WIN0_TAG  = 3'b010;
  localparam logic [4:0] SUB_SEL   = 5'h00;
  localparam logic [4:0] SUB_CTL   = 5'h04;
  localparam logic [4:0] SUB_POP   = 5'h08;
  localparam logic [4:0] SUB_STAT  = 5'h0C;

  localparam logic [31:0] SEL_KEEP    = 32'h3333_3333;
  localparam logic [31:0] NOISE_MUL   = 32'd314159;
  localparam logic [9:0]  SAMPLE_BASE = 10'h200;

  function automatic logic [31:0] noise_advance(input logic [31:0] cur);
    return cur * NOISE_MUL + 32'd1;
  endfunction

  function automatic logic [9:0] sample_from_noise(input logic [31:0] st);
    return SAMPLE_BASE + {7'd0, st[18:16]};
  endfunction

  function automatic logic [31:0] pack_status(input logic [3:0] rd_ptr,
                                              input logic [3:0] wr_ptr,
                                              input logic is_empty,
                                              input logic is_full);
    logic [31:0] w;
    w = '0;
    w[3:0]  = rd_ptr;
    w[7:4]  = wr_ptr;
    w[8]    = is_empty;
    w[12]   = is_full;
    return w;
  endfunction

endpackage

// File: rtl/adc_noise_gen.sv
module adc_noise_gen
  import adc_seq_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  output logic [31:0]         state,
  output logic [SAMPLE_W-1:0] next_sample
);

  logic [31:0] state_nx;

  assign state_nx    = noise_advance(state);
  assign next_sample = SAMPLE_W'(sample_from_noise(state_nx));

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= '0;
    else if (step) state <= state_nx;
  end

  p_noise_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state));

endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [3:0]        rd_ptr,
  output logic [3:0]        wr_ptr,
  output logic              is_empty,
  output logic              is_full,
  output logic              ovf_evt,
  output logic              unf_evt
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  head, tail, head_nx, tail_nx;
  logic              empty_q, full_q, empty_nx, full_nx;
  logic              take, store;

  always_comb begin
    head_nx  = head;
    tail_nx  = tail;
    empty_nx = empty_q;
    full_nx  = full_q;
    take     = pop && !empty_q;
    if (take) begin
      tail_nx  = PTR_W'(tail + 1'b1);
      full_nx  = 1'b0;
      empty_nx = (tail_nx == head);
    end
    store = push && !full_nx;
    if (store) begin
      head_nx  = PTR_W'(head + 1'b1);
      empty_nx = 1'b0;
      full_nx  = (head_nx == tail_nx);
    end
  end

  assign ovf_evt = push && !store;
  assign unf_evt = pop && empty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head    <= '0;
      tail    <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else begin
      head    <= head_nx;
      tail    <= tail_nx;
      empty_q <= empty_nx;
      full_q  <= full_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (store) mem[head] <= push_data;
  end

  assign rd_data  = empty_q ? '0 : mem[tail];
  assign rd_ptr   = 4'(tail);
  assign wr_ptr   = 4'(head);
  assign is_empty = empty_q;
  assign is_full  = full_q;

  p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty_q && full_q));
  p_full_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full_q && !pop) |=> $stable(head));
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty_q) |=> $stable(tail));
  p_pop_clears_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && full_q && !push) |=> !full_q);

endmodule

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs #(
  parameter int NSEQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_enable,
  input  logic            wr_mask,
  input  logic            wr_raw_clr,
  input  logic            wr_err_clr,
  input  logic [NSEQ-1:0] wdata,
  input  logic            set_raw0,
  input  logic            set_ovf,
  input  logic            set_unf,
  output logic [NSEQ-1:0] enable,
  output logic [NSEQ-1:0] mask,
  output logic [NSEQ-1:0] raw,
  output logic [1:0]      err
);

  logic [NSEQ-1:0] raw_set;

  assign raw_set = {{(NSEQ-1){1'b0}}, set_raw0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= '0;
      mask   <= '0;
      raw    <= '0;
      err    <= '0;
    end else begin
      if (wr_enable) enable <= wdata;
      if (wr_mask)   mask   <= wdata;
      raw <= (wr_raw_clr ? (raw & ~wdata) : raw) | raw_set;
      err <= (wr_err_clr ? (err & ~wdata[1:0]) : err) | {set_unf, set_ovf};
    end
  end

  p_raw_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_raw0 |=> raw[0]);
  p_raw_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_raw_clr && wdata[0] && !set_raw0) |=> !raw[0]);
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err[0] && !wr_err_clr) |=> err[0]);

endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo
  import adc_seq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int SAMPLE_W = 10,
  parameter int NSEQ     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        trig,
  output logic        irq
);

  logic              win0;
  logic [4:0]        sub;
  logic              trig_acc, pop_evt;
  logic              wr_enable, wr_mask, wr_raw_clr, wr_err_clr;
  logic [NSEQ-1:0]   enable, mask, raw;
  logic [1:0]        err;
  logic [31:0]       noise;
  logic [SAMPLE_W-1:0] sample, head_data;
  logic [3:0]        rd_ptr, wr_ptr;
  logic              is_empty, is_full, ovf_evt, unf_evt;
  logic [31:0]       sel_q, ctl_q, status_w;

  assign win0 = (bus_addr[7:5] == WIN0_TAG);
  assign sub  = bus_addr[4:0];

  assign trig_acc   = trig && enable[0];
  assign pop_evt    = bus_rd && win0 && (sub == SUB_POP);
  assign wr_enable  = bus_wr && (bus_addr == OFF_ENABLE);
  assign wr_mask    = bus_wr && (bus_addr == OFF_MASK);
  assign wr_raw_clr = bus_wr && (bus_addr == OFF_MIS);
  assign wr_err_clr = bus_wr && (bus_addr == OFF_ERR);

  adc_noise_gen #(.SAMPLE_W(SAMPLE_W)) u_noise (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (trig_acc),
    .state       (noise),
    .next_sample (sample)
  );

  adc_sample_fifo #(.DEPTH(DEPTH), .DATA_W(SAMPLE_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (trig_acc),
    .push_data (sample),
    .pop       (pop_evt),
    .rd_data   (head_data),
    .rd_ptr    (rd_ptr),
    .wr_ptr    (wr_ptr),
    .is_empty  (is_empty),
    .is_full   (is_full),
    .ovf_evt   (ovf_evt),
    .unf_evt   (unf_evt)
  );

  adc_ctl_regs #(.NSEQ(NSEQ)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_enable  (wr_enable),
    .wr_mask    (wr_mask),
    .wr_raw_clr (wr_raw_clr),
    .wr_err_clr (wr_err_clr),
    .wdata      (bus_wdata[NSEQ-1:0]),
    .set_raw0   (trig_acc),
    .set_ovf    (ovf_evt),
    .set_unf    (unf_evt),
    .enable     (enable),
    .mask       (mask),
    .raw        (raw),
    .err        (err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      ctl_q <= '0;
    end else if (bus_wr && win0) begin
      if (sub == SUB_SEL) sel_q <= bus_wdata & SEL_KEEP;
      if (sub == SUB_CTL) ctl_q <= bus_wdata;
    end
  end

  assign status_w = pack_status(rd_ptr, wr_ptr, is_empty, is_full);
  assign irq      = |(raw & mask);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (win0) begin
        case (sub)
          SUB_SEL:  bus_rdata = sel_q;
          SUB_CTL:  bus_rdata = ctl_q;
          SUB_POP:  bus_rdata = 32'(head_data);
          SUB_STAT: bus_rdata = status_w;
          default:  bus_rdata = '0;
        endcase
      end else begin
        case (bus_addr)
          OFF_ENABLE: bus_rdata = 32'(enable);
          OFF_RAW:    bus_rdata = 32'(raw);
          OFF_MASK:   bus_rdata = 32'(mask);
          OFF_MIS:    bus_rdata = 32'(raw & mask);
          OFF_ERR:    bus_rdata = 32'(err);
          default:    bus_rdata = '0;
        endcase
      end
    end
  end

  p_trig_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !enable[0] && !pop_evt) |=> $stable(status_w));
  p_ovf_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_acc && is_full && !pop_evt) |=> err[0]);
  p_unf_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && is_empty) |=> err[1]);

endmodule

// File: tb/adc_seq_fifo_tb_top.sv
module adc_seq_fifo_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, trig = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_noise = 0;
  logic [9:0]  m_q[$];
  int m_head = 0, m_tail = 0;
  bit m_empty = 1, m_full = 0, m_en = 0;

  always #4 clk = ~clk;

  adc_seq_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig(trig), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  function automatic logic [31:0] exp_status();
    return (m_tail & 32'hF) | ((m_head & 32'hF) << 4) |
           (32'(m_empty) << 8) | (32'(m_full) << 12);
  endfunction

  task automatic fire();
    longint unsigned p;
    @(negedge clk);
    trig = 1;
    @(posedge clk); #1;
    trig = 0;
    if (m_en) begin
      p = 64'(m_noise) * 64'd314159 + 64'd1;
      m_noise = p[31:0];
      if (!m_full) begin
        m_q.push_back(10'd512 + 10'((m_noise >> 16) % 8));
        m_head = (m_head + 1) % 16;
        m_empty = 0;
        m_full = (m_head == m_tail);
      end
    end
  endtask

  task automatic pop_check(input string req);
    logic [31:0] v, e;
    e = 0;
    if (!m_empty) begin
      e = 32'(m_q.pop_front());
      m_tail = (m_tail + 1) % 16;
      m_full = 0;
      m_empty = (m_tail == m_head);
    end
    rd(8'h48, v);
    chk(req, v, e);
  endtask

  task automatic stat_check(input string req);
    logic [31:0] v;
    rd(8'h4C, v);
    chk(req, v, exp_status());
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    stat_check("R1 status");
    rd(8'h00, v); chk("R1 enable", v, 0);
    rd(8'h04, v); chk("R1 raw", v, 0);
    rd(8'h08, v); chk("R1 mask", v, 0);
    rd(8'h10, v); chk("R1 err", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R3 enable keeps 4 bits
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R3 enable mask", v, 32'hF);
    // R2 triggers ignored with bit0 clear
    wr(8'h00, 32'h0000_000E);
    fire(); fire();
    stat_check("R2 status unchanged");
    rd(8'h04, v); chk("R2 raw unchanged", v, 0);

    // R12 select and control registers
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R12 select", v, 32'h3333_3333);
    wr(8'h44, 32'hA5C3_1E2D);
    rd(8'h44, v); chk("R12 control", v, 32'hA5C3_1E2D);

    // R13 other windows read zero and do not pop
    rd(8'h68, v); chk("R13 window1 read", v, 0);
    rd(8'hA8, v); chk("R13 window3 read", v, 0);
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R13 select untouched", v, 32'h3333_3333);

    // R7 pop from empty
    pop_check("R7 empty pop value");
    stat_check("R7 pointers kept");
    rd(8'h10, v); chk("R7 underflow flag", v, 32'h2);
    // R11 clear
    wr(8'h10, 32'h2);
    rd(8'h10, v); chk("R11 underflow cleared", v, 0);

    // R4 fill with status after each push
    wr(8'h00, 32'h1); m_en = 1;
    for (int i = 0; i < 16; i++) begin
      fire();
      stat_check("R4 fill status");
    end
    rd(8'h04, v); chk("R9 raw set", v, 1);
    chk("R9 irq masked off", 32'(irq), 0);
    rd(8'h0C, v); chk("R9 masked read off", v, 0);
    wr(8'h08, 32'hFFFF_FFF1);
    rd(8'h08, v); chk("R9 mask width", v, 32'h1);
    chk("R9 irq on", 32'(irq), 1);
    rd(8'h0C, v); chk("R9 masked read on", v, 1);

    // R5 overflow (noise still advances, R8)
    fire();
    stat_check("R5 full kept");
    rd(8'h10, v); chk("R5 overflow flag", v, 32'h1);
    wr(8'h10, 32'h1);
    rd(8'h10, v); chk("R11 overflow cleared", v, 0);

    // R10 raw clear
    wr(8'h0C, 32'h1);
    rd(8'h04, v); chk("R10 raw cleared", v, 0);
    chk("R10 irq low", 32'(irq), 0);

    // R6 and R8 drain
    for (int i = 0; i < 16; i++) begin
      pop_check("R6 R8 drain value");
      stat_check("R6 drain status");
    end
    pop_check("R7 pop after drain");
    rd(8'h10, v); chk("R7 underflow again", v, 32'h2);
    wr(8'h10, 32'h3);

    // wrap sweep: two pushes, one pop
    for (int i = 0; i < 60; i++) begin
      if (i % 3 == 2) pop_check("R6 sweep value");
      else fire();
      stat_check("R4 sweep status");
    end
    while (!m_empty) begin
      pop_check("R8 sweep drain value");
      stat_check("R6 sweep drain status");
    end

    // R10 set wins over clear in the same cycle
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'h0C; bus_wdata = 32'h1; trig = 1;
    @(posedge clk); #1;
    bus_wr = 0; trig = 0;
    begin
      longint unsigned p;
      p = 64'(m_noise) * 64'd314159 + 64'd1;
      m_noise = p[31:0];
      m_q.push_back(10'd512 + 10'((m_noise >> 16) % 8));
      m_head = (m_head + 1) % 16; m_empty = 0; m_full = (m_head == m_tail);
    end
    rd(8'h04, v); chk("R10 set wins", v, 1);
    pop_check("R8 last value");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule